// File: doc/BRIEF.md
# Read Burst to Single-Beat Splitter

This block joins a burst-capable read manager to a subordinate that only understands single-beat reads. It takes one read request, with its length, transfer size, address mode, start address and transaction tag. It then issues one single-beat read on the subordinate side for each beat of that burst. Each returned word is handed back to the manager as one beat of a single burst. The final beat carries the last marker. The manager sees exactly the transaction it asked for and cannot tell that the request was broken up.

Only one burst is in flight at a time. The request port stays closed from acceptance until the manager has taken the final beat. A one-entry holding register sits on the return path. The subordinate's data handshake is enabled only while that register is empty, so the manager can stall for any length of time without any word being lost.

Top module: `rd_burst_split`

## Requirements
- R1: While reset is high and in the first cycle after it, `reqReady` is 1, and `beatValid` and `subAddrValid` are 0.
- R2: An accepted request with `reqLen` = N produces exactly N+1 beats on the beat port. No further beat appears until a new request is accepted.
- R3: `beatLast` is 1 on the (N+1)-th beat of a burst and 0 on every earlier beat.
- R4: In incrementing mode (`reqMode` = 1, and also 2 or 3, which are handled as incrementing), the first subordinate read uses the start address unchanged, even when it is unaligned. Each later read uses the previous address rounded down to a multiple of 2^`reqSize` bytes, plus 2^`reqSize`, with the result taken modulo 2^ADDR_W.
- R5: In fixed mode (`reqMode` = 0), every subordinate read of the burst uses the start address.
- R6: Each beat carries the full data word returned by its subordinate read, unchanged, and `beatId` equals the `reqId` captured when the request was accepted.
- R7: Each beat's `beatResp` equals the response code of its own subordinate read (0 okay, 2 subordinate error, 3 decode error). An error response does not end the burst early.
- R8: `reqReady` is 0 from the cycle after a request is accepted until the final beat has been taken. It is 1 again in the cycle after that.
- R9: `subDataReady` is 1 only when no beat is waiting on the beat port. Any amount of stalling by `beatReady` leaves the data and order of the beats unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Burst request valid |
| reqReady | output | 1 | Burst request accepted when high with reqValid |
| reqId | input | ID_W | Transaction tag of the request |
| reqAddr | input | ADDR_W | Byte start address |
| reqLen | input | LEN_W | Beats in the burst minus one |
| reqSize | input | 3 | Log2 of bytes per beat |
| reqMode | input | 2 | 0 fixed address, any other value incrementing |
| beatValid | output | 1 | Burst beat valid |
| beatReady | input | 1 | Manager takes the beat |
| beatId | output | ID_W | Tag echoed from the request |
| beatData | output | DATA_W | Beat data word |
| beatResp | output | 2 | Beat response code |
| beatLast | output | 1 | Final beat of the burst |
| subAddrValid | output | 1 | Single-beat read address valid |
| subAddrReady | input | 1 | Subordinate takes the address |
| subAddr | output | ADDR_W | Single-beat read address |
| subDataValid | input | 1 | Subordinate read data valid |
| subDataReady | output | 1 | Splitter takes the read data |
| subData | input | DATA_W | Subordinate read data |
| subResp | input | 2 | Subordinate read response |

## Verification
A wrong beat counter shows up at the beat port within the burst it corrupts. The last marker lands on the wrong beat, or extra or missing beats appear before the next request opens. A bad address step shows up on the very beat where it occurs, because the bench subordinate derives every data word and response code from the address it was given. A holding flag that is stuck or cleared too early shows up within a few cycles, either as a duplicated or dropped word under random stalls or as a stalled burst.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DRAIN
  } rbsState_t;

  typedef struct packed {
    logic loadReq;      // request handshake this cycle
    logic captureBeat;  // subordinate data handshake this cycle
    logic captureLast;  // the captured beat closes the burst
  } rbsStrobe_t;

  localparam logic [1:0] MODE_FIXED = 2'd0;
endpackage

// File: rtl/rbs_ctrl.sv
module rbs_ctrl
  import rbs_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqValid,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             subAddrReady,
  input  logic             subDataValid,
  input  logic             beatReady,
  output logic             reqReady,
  output logic             subAddrValid,
  output logic             subDataReady,
  output logic             beatValid,
  output rbsStrobe_t       strobe
);
  rbsState_t        state;
  logic [LEN_W-1:0] beatsLeft;
  logic             holdFull;
  logic             popBeat;

  always_comb begin
    reqReady           = (state == ST_IDLE);
    subAddrValid       = (state == ST_ISSUE);
    subDataReady       = (state == ST_WAIT) && !holdFull;
    beatValid          = holdFull;
    popBeat            = holdFull && beatReady;
    strobe.loadReq     = reqValid && reqReady;
    strobe.captureBeat = subDataValid && subDataReady;
    strobe.captureLast = (beatsLeft == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      beatsLeft <= '0;
      holdFull  <= 1'b0;
    end else begin
      if (strobe.captureBeat) holdFull <= 1'b1;
      else if (popBeat)       holdFull <= 1'b0;

      unique case (state)
        ST_IDLE: if (strobe.loadReq) begin
          beatsLeft <= reqLen;
          state     <= ST_ISSUE;
        end
        ST_ISSUE: if (subAddrReady) state <= ST_WAIT;
        ST_WAIT: if (strobe.captureBeat) begin
          if (strobe.captureLast) state <= ST_DRAIN;
          else begin
            beatsLeft <= beatsLeft - 1'b1;
            state     <= ST_ISSUE;
          end
        end
        ST_DRAIN: if (popBeat) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rbs_data.sv
module rbs_data
  import rbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  rbsStrobe_t        strobe,
  input  logic [ID_W-1:0]   reqId,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqSize,
  input  logic [1:0]        reqMode,
  input  logic [DATA_W-1:0] subData,
  input  logic [1:0]        subResp,
  output logic [ADDR_W-1:0] subAddr,
  output logic [ID_W-1:0]   beatId,
  output logic [DATA_W-1:0] beatData,
  output logic [1:0]        beatResp,
  output logic              beatLast
);
  logic [ADDR_W-1:0] curAddr;
  logic [ADDR_W-1:0] stepBytes;
  logic [ADDR_W-1:0] nextAddr;
  logic [2:0]        sizeReg;
  logic              fixedMode;

  always_comb begin
    stepBytes = ADDR_W'(1) << sizeReg;
    nextAddr  = fixedMode ? curAddr
                          : (curAddr & ~(stepBytes - 1'b1)) + stepBytes;
    subAddr   = curAddr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curAddr   <= '0;
      sizeReg   <= '0;
      fixedMode <= 1'b0;
      beatId    <= '0;
      beatData  <= '0;
      beatResp  <= '0;
      beatLast  <= 1'b0;
    end else begin
      if (strobe.loadReq) begin
        curAddr   <= reqAddr;
        sizeReg   <= reqSize;
        fixedMode <= (reqMode == MODE_FIXED);
        beatId    <= reqId;
      end
      if (strobe.captureBeat) begin
        curAddr  <= nextAddr;
        beatData <= subData;
        beatResp <= subResp;
        beatLast <= strobe.captureLast;
      end
    end
  end
endmodule

// File: rtl/rd_burst_split.sv
module rd_burst_split
  import rbs_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ID_W-1:0]   reqId,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [2:0]        reqSize,
  input  logic [1:0]        reqMode,
  output logic              beatValid,
  input  logic              beatReady,
  output logic [ID_W-1:0]   beatId,
  output logic [DATA_W-1:0] beatData,
  output logic [1:0]        beatResp,
  output logic              beatLast,
  output logic              subAddrValid,
  input  logic              subAddrReady,
  output logic [ADDR_W-1:0] subAddr,
  input  logic              subDataValid,
  output logic              subDataReady,
  input  logic [DATA_W-1:0] subData,
  input  logic [1:0]        subResp
);
  rbsStrobe_t strobe;

  rbs_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqLen(reqLen),
    .subAddrReady(subAddrReady), .subDataValid(subDataValid),
    .beatReady(beatReady), .reqReady(reqReady), .subAddrValid(subAddrValid),
    .subDataReady(subDataReady), .beatValid(beatValid), .strobe(strobe)
  );

  rbs_data #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W)) data_i (
    .clk(clk), .rst(rst), .strobe(strobe), .reqId(reqId), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqMode(reqMode), .subData(subData), .subResp(subResp),
    .subAddr(subAddr), .beatId(beatId), .beatData(beatData),
    .beatResp(beatResp), .beatLast(beatLast)
  );
endmodule

// File: rtl/rbs_checker.sv
module rbs_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reqValid,
  input logic              reqReady,
  input logic [LEN_W-1:0]  reqLen,
  input logic              beatValid,
  input logic              beatReady,
  input logic [DATA_W-1:0] beatData,
  input logic [1:0]        beatResp,
  input logic              beatLast,
  input logic              subAddrValid,
  input logic              subAddrReady,
  input logic [ADDR_W-1:0] subAddr,
  input logic              subDataReady
);
  logic [LEN_W-1:0] lenReg;
  logic [LEN_W-1:0] beatCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      lenReg  <= '0;
      beatCnt <= '0;
    end else if (reqValid && reqReady) begin
      lenReg  <= reqLen;
      beatCnt <= '0;
    end else if (beatValid && beatReady) begin
      beatCnt <= beatCnt + 1'b1;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> reqReady && !beatValid && !subAddrValid);

  a_r3_last_position: assert property (@(posedge clk) disable iff (rst)
    beatValid && beatReady |-> (beatLast == (beatCnt == lenReg)));

  a_r8_closed_in_burst: assert property (@(posedge clk) disable iff (rst)
    beatValid |-> !reqReady);

  a_r8_reopen_after_last: assert property (@(posedge clk) disable iff (rst)
    beatValid && beatReady && beatLast |=> reqReady);

  a_r9_hold_blocks_data: assert property (@(posedge clk) disable iff (rst)
    subDataReady |-> !beatValid);

  a_r9_beat_held: assert property (@(posedge clk) disable iff (rst)
    beatValid && !beatReady |=> beatValid && $stable(beatData)
                                && $stable(beatResp) && $stable(beatLast));

  a_r4_addr_held: assert property (@(posedge clk) disable iff (rst)
    subAddrValid && !subAddrReady |=> subAddrValid && $stable(subAddr));
endmodule

bind rd_burst_split rbs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) chk_i (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady), .reqLen(reqLen),
  .beatValid(beatValid), .beatReady(beatReady), .beatData(beatData),
  .beatResp(beatResp), .beatLast(beatLast), .subAddrValid(subAddrValid),
  .subAddrReady(subAddrReady), .subAddr(subAddr), .subDataReady(subDataReady)
);

// File: tb/rd_burst_split_tb_top.sv
module rd_burst_split_tb_top;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int ID_W   = 4;
  localparam int LEN_W  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0, reqReady;
  logic [ID_W-1:0] reqId = '0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [LEN_W-1:0] reqLen = '0;
  logic [2:0] reqSize = '0;
  logic [1:0] reqMode = '0;
  logic beatValid, beatReady = 1'b0, beatLast;
  logic [ID_W-1:0] beatId;
  logic [DATA_W-1:0] beatData;
  logic [1:0] beatResp;
  logic subAddrValid, subAddrReady = 1'b0, subDataValid = 1'b0, subDataReady;
  logic [ADDR_W-1:0] subAddr;
  logic [DATA_W-1:0] subData = '0;
  logic [1:0] subResp = '0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rd_burst_split #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_W(ID_W), .LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady), .reqId(reqId),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqSize(reqSize), .reqMode(reqMode),
    .beatValid(beatValid), .beatReady(beatReady), .beatId(beatId),
    .beatData(beatData), .beatResp(beatResp), .beatLast(beatLast),
    .subAddrValid(subAddrValid), .subAddrReady(subAddrReady), .subAddr(subAddr),
    .subDataValid(subDataValid), .subDataReady(subDataReady), .subData(subData),
    .subResp(subResp)
  );

  // Subordinate model: word and response are pure functions of the address.
  function automatic logic [DATA_W-1:0] wordOf(input logic [ADDR_W-1:0] a);
    return {~a, a};
  endfunction
  function automatic logic [1:0] respOf(input logic [ADDR_W-1:0] a);
    if (a[5:3] == 3'b101) return 2'd2;
    if (a[5:3] == 3'b110) return 2'd3;
    return 2'd0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  initial begin : sub_model
    bit aHs = 0, dHs = 0, havePend = 0;
    logic [ADDR_W-1:0] pendAddr = '0;
    int delay = 0;
    forever begin
      @(negedge clk);
      if (rst) begin
        havePend = 0; subAddrReady = 0; subDataValid = 0;
      end else begin
        if (aHs) begin
          havePend = 1; pendAddr = subAddr; delay = int'($urandom % 3);
        end
        if (dHs) begin
          havePend = 0; subDataValid = 0;
        end
        subAddrReady = !havePend && ($urandom % 2 == 0);
        if (havePend && !subDataValid) begin
          if (delay == 0) begin
            subDataValid = 1; subData = wordOf(pendAddr); subResp = respOf(pendAddr);
          end else delay--;
        end
      end
      #(CLK_P/2 - 1);
      aHs = subAddrValid && subAddrReady;
      dHs = subDataValid && subDataReady;
    end
  end

  function automatic logic [ADDR_W-1:0] expAddr(input logic [ADDR_W-1:0] start,
      input int size, input int mode, input int k);
    logic [ADDR_W-1:0] step = ADDR_W'(1) << size;
    if (mode == 0 || k == 0) return start;
    return (start & ~(step - 1'b1)) + ADDR_W'(k) * step;
  endfunction

  task automatic runBurst(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] a,
                          input int len, input int size, input int mode);
    int got = 0;
    bit closedOk = 1, holdOk = 1, done = 0;
    @(negedge clk);
    reqValid = 1; reqId = id; reqAddr = a; reqLen = LEN_W'(len);
    reqSize = 3'(size); reqMode = 2'(mode);
    while (!done) begin
      #(CLK_P/2 - 1);
      done = reqReady;
      @(negedge clk);
    end
    reqValid = 0;
    while (got <= len) begin
      beatReady = ($urandom % 3 != 0);
      #(CLK_P/2 - 1);
      if (reqReady) closedOk = 0;
      if (subDataReady && beatValid) holdOk = 0;
      if (beatValid && beatReady) begin
        logic [ADDR_W-1:0] ea = expAddr(a, size, mode, got);
        if (mode == 0)
          chk(beatData == wordOf(ea), "R5 fixed-mode data", 64'(beatData), 64'(wordOf(ea)));
        else
          chk(beatData == wordOf(ea), "R4 incr-mode data", 64'(beatData), 64'(wordOf(ea)));
        chk(beatId == id, "R6 tag echo", 64'(beatId), 64'(id));
        chk(beatResp == respOf(ea), "R7 beat response", 64'(beatResp), 64'(respOf(ea)));
        chk(beatLast == (got == len), "R3 last marker", 64'(beatLast), 64'(got == len));
        got++;
      end
      @(negedge clk);
    end
    beatReady = 0;
    chk(closedOk, "R8 request closed during burst", 64'(closedOk), 64'd1);
    chk(holdOk, "R9 data blocked while beat waits", 64'(holdOk), 64'd1);
    repeat (2) begin
      #(CLK_P/2 - 1);
      chk(!beatValid, "R2 no extra beat", 64'(beatValid), 64'd0);
      chk(reqReady, "R8 request reopened", 64'(reqReady), 64'd1);
      @(negedge clk);
    end
  endtask

  initial begin : main
    logic [ADDR_W-1:0] start;
    repeat (3) @(negedge clk);
    #(CLK_P/2 - 1);
    chk(reqReady && !beatValid && !subAddrValid, "R1 reset state",
        64'({reqReady, beatValid, subAddrValid}), 64'b100);
    @(negedge clk);
    rst = 0;
    #(CLK_P/2 - 1);
    chk(reqReady && !beatValid && !subAddrValid, "R1 after reset",
        64'({reqReady, beatValid, subAddrValid}), 64'b100);
    for (int mode = 0; mode < 3; mode++)
      for (int size = 0; size < 3; size++)
        for (int len = 0; len < 8; len++)
          for (int off = 0; off < 4; off++) begin
            start = ADDR_W'(16'h0100 * (mode * 24 + size * 8 + len) + off * 5 + 16'h20);
            runBurst(ID_W'(len + off), start, len, size, mode);
          end
    // Long incrementing burst crossing the top of the address space.
    runBurst(4'hA, 16'hFFF2, 20, 2, 1);
    // Mode 3 behaves as incrementing.
    runBurst(4'h5, 16'h0213, 6, 1, 3);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog R2 burst stalled act=%h exp=%h", 64'd0, 64'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule